// File: doc/BRIEF.md
# Prescaled 64-bit Machine Timer

This block is a machine-mode timer for one hart. A small run-state machine gates a prescaler. The prescaler emits a tick once every (prescale + 1) running clock cycles. On each tick a 64-bit count grows by a programmable step. The count wraps modulo 2^64.

Every compare channel holds a 64-bit threshold. When the count is at or above that threshold, the channel latches a sticky status bit. That bit is masked by a per-channel enable to form the channel's interrupt output. A write-only test register lets software force status bits.

Software reaches all state through a flat 32-bit register port. A write happens in the cycle that `reg_we` is high. Reads are combinational from `reg_addr`. The 64-bit quantities are split into a lower word and an upper word.

The run-state machine has two states:
- `TMR_HALT`: the prescaler and count are frozen.
- `TMR_RUN`: the prescaler advances.

It has two transitions:
- go (`TMR_HALT` to `TMR_RUN`): a control write with bit 0 set.
- stop (`TMR_RUN` to `TMR_HALT`): a control write with bit 0 clear.

Top module: `mtimer_top`

## Requirements
- R1: After reset the timer reads as follows:
  - Control reads 0 (halted).
  - Configuration reads 0x00010000, which is prescale 0 in bits 11:0 and step 1 in bits 23:16.
  - Both count words read 0.
  - Every compare word reads 0xFFFFFFFF.
  - Enable and status read 0, and `irq` is 0.
- R2: A control write with bit 0 = 1 enters `TMR_RUN`, and one with bit 0 = 0 enters `TMR_HALT`. While halted, the count and the prescaler hold their values.
- R3: While running, a tick occurs once every (prescale + 1) clock edges, and each tick adds step to the count. Starting from a freshly restarted prescaler, E edges in `TMR_RUN` add floor(E/(prescale+1))*step.
- R4: Any write to the configuration register restarts the prescaler count at 0.
- R5: Each count word can be written on its own. The count wraps modulo 2^64, carrying from the lower word into the upper word.
- R6: A software write to a count word replaces that word in that cycle, and the tick increment of that cycle is dropped.
- R7: A channel is expired when the count is greater than or equal to its compare value, both taken as unsigned 64-bit numbers. Its status bit is set on the clock edge after the condition holds, so a compare write takes effect one cycle later.
- R8: Writing 1 to a status bit clears it. When that write meets a set from expiry or test in the same cycle, the set wins.
- R9: A status bit stays set after the expiry condition goes away, until software clears it.
- R10: `irq[c]` is status bit c ANDed with enable bit c. The enable register holds one bit per channel, at bit c.
- R11: The test register is write-only and always reads 0. Writing 1 to bit c sets status bit c on that write's clock edge.
- R12: The address map, with N channels, is:
  - Control at 0x000.
  - Configuration at 0x100.
  - Count lower word at 0x104 and upper word at 0x108.
  - Compare c lower word at 0x10C+8c and upper word at 0x110+8c.
  - Enable at 0x10C+8N, status at 0x110+8N, test at 0x114+8N.
  - Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq | output | NCHAN | Per-channel interrupt outputs |

## Verification
Register writes, the count and the enable-gated `irq` are visible right after the write edge. The bench therefore reads them half a cycle later, at the falling edge. A status bit raised by expiry appears one edge later than the write that caused it. The bench first reads the bit as clear at that falling edge, then reads it again one cycle later and expects it set.

For counting runs, the bench counts every edge spent in the running state, including the edge of the stop write. It predicts floor(E/(prescale+1))*step and compares the words only while the timer is halted.

// File: rtl/mtimer_pkg.sv
`timescale 1ns/1ps
package mtimer_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned CNT_W   = 2 * WORD_W;
    localparam int unsigned A_CTRL  = 'h000;
    localparam int unsigned A_CFG   = 'h100;
    localparam int unsigned A_CLO   = 'h104;
    localparam int unsigned A_CHI   = 'h108;
    localparam int unsigned A_CMP0  = 'h10C;
    localparam int unsigned STEP_LSB = 16;

    typedef enum logic {
        TMR_HALT = 1'b0,
        TMR_RUN  = 1'b1
    } run_state_e;

    function automatic int unsigned a_cmp_lo(int unsigned c);
        return A_CMP0 + 8 * c;
    endfunction

    function automatic int unsigned a_cmp_hi(int unsigned c);
        return A_CMP0 + 8 * c + 4;
    endfunction

    function automatic int unsigned a_ie(int unsigned n);
        return A_CMP0 + 8 * n;
    endfunction

    function automatic int unsigned a_stat(int unsigned n);
        return A_CMP0 + 8 * n + 4;
    endfunction

    function automatic int unsigned a_test(int unsigned n);
        return A_CMP0 + 8 * n + 8;
    endfunction
endpackage

// File: rtl/mtimer_prescale.sv
`timescale 1ns/1ps
module mtimer_prescale
    import mtimer_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             stop,
    input  logic             restart,
    input  logic [PRE_W-1:0] prescale,
    output logic             run_o,
    output logic             tick_o
);
    run_state_e       state_q, state_d;
    logic [PRE_W-1:0] pcnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMR_HALT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_HALT: if (go)   state_d = TMR_RUN;
            TMR_RUN:  if (stop) state_d = TMR_HALT;
        endcase
    end

    // Outputs
    always_comb begin
        run_o  = (state_q == TMR_RUN);
        tick_o = run_o && (pcnt_q >= prescale);
    end

    // Prescaler count: restarts on config write or tick, frozen when halted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pcnt_q <= '0;
        else if (restart)  pcnt_q <= '0;
        else if (tick_o)   pcnt_q <= '0;
        else if (run_o)    pcnt_q <= pcnt_q + 1'b1;
    end
endmodule

// File: rtl/mtimer_count.sv
`timescale 1ns/1ps
module mtimer_count
    import mtimer_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [STEP_W-1:0] step,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_o
);
    // Software write wins over the tick increment of the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt_o[WORD_W-1:0]     <= wdata;
            if (wr_hi) cnt_o[CNT_W-1:WORD_W] <= wdata;
        end else if (tick) begin
            cnt_o <= cnt_o + CNT_W'(step);
        end
    end
endmodule

// File: rtl/mtimer_chan.sv
`timescale 1ns/1ps
module mtimer_chan
    import mtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              clr,
    input  logic              force_set,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              hit_o,
    output logic              status_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_o <= '1;
        end else begin
            if (wr_lo) cmp_o[WORD_W-1:0]     <= wdata;
            if (wr_hi) cmp_o[CNT_W-1:WORD_W] <= wdata;
        end
    end

    assign hit_o = (cnt >= cmp_o);

    // Set (expiry or test) dominates a write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_o <= 1'b0;
        else        status_o <= hit_o | force_set | (status_o & ~clr);
    end
endmodule

// File: rtl/mtimer_top.sv
`timescale 1ns/1ps
module mtimer_top
    import mtimer_pkg::*;
#(
    parameter int NCHAN  = 2,
    parameter int ADDR_W = 12,
    parameter int PRE_W  = 12,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NCHAN-1:0]  irq
);
    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_CFG  = ADDR_W'(A_CFG);
    localparam logic [ADDR_W-1:0] AD_CLO  = ADDR_W'(A_CLO);
    localparam logic [ADDR_W-1:0] AD_CHI  = ADDR_W'(A_CHI);
    localparam logic [ADDR_W-1:0] AD_IE   = ADDR_W'(a_ie(NCHAN));
    localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(a_stat(NCHAN));
    localparam logic [ADDR_W-1:0] AD_TEST = ADDR_W'(a_test(NCHAN));

    logic              wr_ctrl, wr_cfg, wr_clo, wr_chi, wr_ie, wr_stat, wr_test;
    logic [PRE_W-1:0]  pre_q;
    logic [STEP_W-1:0] step_q;
    logic [NCHAN-1:0]  ie_q;
    logic              run_w, tick_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [NCHAN-1:0]  hit_w, status_w, clr_w, tst_set_w;
    logic [CNT_W-1:0]  cmp_w [NCHAN];

    assign wr_ctrl = reg_we && (reg_addr == AD_CTRL);
    assign wr_cfg  = reg_we && (reg_addr == AD_CFG);
    assign wr_clo  = reg_we && (reg_addr == AD_CLO);
    assign wr_chi  = reg_we && (reg_addr == AD_CHI);
    assign wr_ie   = reg_we && (reg_addr == AD_IE);
    assign wr_stat = reg_we && (reg_addr == AD_STAT);
    assign wr_test = reg_we && (reg_addr == AD_TEST);

    assign clr_w     = wr_stat ? reg_wdata[NCHAN-1:0] : '0;
    assign tst_set_w = wr_test ? reg_wdata[NCHAN-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            step_q <= STEP_W'(1);
            ie_q   <= '0;
        end else begin
            if (wr_cfg) begin
                pre_q  <= reg_wdata[PRE_W-1:0];
                step_q <= reg_wdata[STEP_LSB +: STEP_W];
            end
            if (wr_ie) ie_q <= reg_wdata[NCHAN-1:0];
        end
    end

    mtimer_prescale #(.PRE_W(PRE_W)) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (wr_ctrl &&  reg_wdata[0]),
        .stop     (wr_ctrl && !reg_wdata[0]),
        .restart  (wr_cfg),
        .prescale (pre_q),
        .run_o    (run_w),
        .tick_o   (tick_w)
    );

    mtimer_count #(.STEP_W(STEP_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_w),
        .step  (step_q),
        .wr_lo (wr_clo),
        .wr_hi (wr_chi),
        .wdata (reg_wdata),
        .cnt_o (cnt_w)
    );

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        mtimer_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (reg_we && (reg_addr == ADDR_W'(a_cmp_lo(c)))),
            .wr_hi     (reg_we && (reg_addr == ADDR_W'(a_cmp_hi(c)))),
            .wdata     (reg_wdata),
            .cnt       (cnt_w),
            .clr       (clr_w[c]),
            .force_set (tst_set_w[c]),
            .cmp_o     (cmp_w[c]),
            .hit_o     (hit_w[c]),
            .status_o  (status_w[c])
        );
    end

    assign irq = status_w & ie_q;

    // Read mux; test register and unmapped space read 0
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AD_CTRL) begin
            reg_rdata[0] = run_w;
        end else if (reg_addr == AD_CFG) begin
            reg_rdata[PRE_W-1:0]          = pre_q;
            reg_rdata[STEP_LSB +: STEP_W] = step_q;
        end else if (reg_addr == AD_CLO) begin
            reg_rdata = cnt_w[WORD_W-1:0];
        end else if (reg_addr == AD_CHI) begin
            reg_rdata = cnt_w[CNT_W-1:WORD_W];
        end else if (reg_addr == AD_IE) begin
            reg_rdata[NCHAN-1:0] = ie_q;
        end else if (reg_addr == AD_STAT) begin
            reg_rdata[NCHAN-1:0] = status_w;
        end
        for (int c = 0; c < NCHAN; c++) begin
            if (reg_addr == ADDR_W'(a_cmp_lo(c))) reg_rdata = cmp_w[c][WORD_W-1:0];
            if (reg_addr == ADDR_W'(a_cmp_hi(c))) reg_rdata = cmp_w[c][CNT_W-1:WORD_W];
        end
    end
endmodule

// File: rtl/mtimer_checker.sv
`timescale 1ns/1ps
module mtimer_checker
    import mtimer_pkg::*;
#(
    parameter int NCHAN  = 2,
    parameter int ADDR_W = 12,
    parameter int STEP_W = 8,
    parameter int PRE_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              run,
    input logic              tick,
    input logic [PRE_W-1:0]  prescale,
    input logic [STEP_W-1:0] step,
    input logic [CNT_W-1:0]  cnt,
    input logic [NCHAN-1:0]  hit,
    input logic [NCHAN-1:0]  status,
    input logic [NCHAN-1:0]  tst_set
);
    localparam logic [ADDR_W-1:0] AD_TEST = ADDR_W'(a_test(NCHAN));

    assert_halt_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reg_we) |=> $stable(cnt));

    assert_tick_adds_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reg_we) |=> (cnt == $past(cnt) + CNT_W'($past(step))));

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (prescale != '0) && !reg_we) |=> !tick);

    assert_expiry_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((status & $past(hit)) == $past(hit)));

    assert_status_rise_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~$past(status) & ~$past(hit) & ~$past(tst_set)) == '0);

    assert_test_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AD_TEST) |-> (reg_rdata == '0));
endmodule

bind mtimer_top mtimer_checker #(
    .NCHAN(NCHAN), .ADDR_W(ADDR_W), .STEP_W(STEP_W), .PRE_W(PRE_W)
) u_mtimer_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .run      (run_w),
    .tick     (tick_w),
    .prescale (pre_q),
    .step     (step_q),
    .cnt      (cnt_w),
    .hit      (hit_w),
    .status   (status_w),
    .tst_set  (tst_set_w)
);

// File: tb/mtimer_top_bench.sv
`timescale 1ns/1ps
module mtimer_top_bench;
    localparam int NCHAN = 2;
    localparam logic [11:0] AD_CTRL = 12'h000;
    localparam logic [11:0] AD_CFG  = 12'h100;
    localparam logic [11:0] AD_CLO  = 12'h104;
    localparam logic [11:0] AD_CHI  = 12'h108;
    localparam logic [11:0] AD_C0LO = 12'h10C;
    localparam logic [11:0] AD_C0HI = 12'h110;
    localparam logic [11:0] AD_C1LO = 12'h114;
    localparam logic [11:0] AD_C1HI = 12'h118;
    localparam logic [11:0] AD_IE   = 12'h11C;
    localparam logic [11:0] AD_STAT = 12'h120;
    localparam logic [11:0] AD_TEST = 12'h124;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [11:0]       reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NCHAN-1:0]  irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mtimer_top #(.NCHAN(NCHAN)) u_mtimer_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called between a falling and a rising edge; returns after the next falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    function automatic logic [63:0] model_count(input logic [63:0] start, input int edges,
                                                input int pre, input int stp);
        return start + 64'(edges / (pre + 1)) * 64'(stp);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, lo, hi;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(AD_CTRL, v); chk("R1 ctrl", 64'(v), 64'h0);
        rd(AD_CFG,  v); chk("R1 cfg", 64'(v), 64'h0001_0000);
        rd(AD_CLO,  v); chk("R1 cnt lo", 64'(v), 64'h0);
        rd(AD_C0LO, v); chk("R1 cmp0 lo", 64'(v), 64'hFFFF_FFFF);
        rd(AD_C1HI, v); chk("R1 cmp1 hi", 64'(v), 64'hFFFF_FFFF);
        rd(AD_STAT, v); chk("R1 status", 64'(v), 64'h0);
        chk("R1 irq", 64'(irq), 64'h0);
        rd(12'h0F0, v); chk("R12 unmapped", 64'(v), 64'h0);

        // R3 R4 R5 random counting runs
        for (int i = 0; i < 24; i++) begin
            int pre, stp, k;
            logic [63:0] start, exp;
            pre = int'($urandom_range(0, 9));
            stp = int'($urandom_range(0, 255));
            k   = int'($urandom_range(0, 40));
            if (i % 4 == 0) start = 64'hFFFF_FFFF_FFFF_FF00 | 64'($urandom_range(0, 255));
            else            start = {$urandom(), $urandom()};
            wr(AD_CFG, (32'(stp) << 16) | 32'(pre));   // R4 restarts prescaler
            wr(AD_CLO, start[31:0]);
            wr(AD_CHI, start[63:32]);
            wr(AD_CTRL, 32'h1);
            rd(AD_CTRL, v); chk("R2 running", 64'(v), 64'h1);
            repeat (k) @(negedge clk);
            wr(AD_CTRL, 32'h0);
            exp = model_count(start, k + 1, pre, stp);
            rd(AD_CLO, lo); rd(AD_CHI, hi);
            chk("R3 R4 R5 count", {hi, lo}, exp);
            repeat (5) @(negedge clk);
            rd(AD_CLO, lo); rd(AD_CHI, hi);
            chk("R2 frozen", {hi, lo}, exp);
        end

        // R7 compare by write, latency one edge
        wr(AD_CLO, 32'd100); wr(AD_CHI, 32'd0);
        wr(AD_STAT, 32'h3);
        rd(AD_STAT, v); chk("R8 cleared", 64'(v), 64'h0);
        wr(AD_C0LO, 32'd100);
        rd(AD_STAT, v); chk("R7 not yet", 64'(v), 64'h0);
        wr(AD_C0HI, 32'd0);
        rd(AD_STAT, v); chk("R7 one cycle later", 64'(v), 64'h0);
        @(negedge clk);
        rd(AD_STAT, v); chk("R7 equal expires", 64'(v), 64'h1);
        chk("R10 masked", 64'(irq), 64'h0);
        wr(AD_IE, 32'h1);
        chk("R10 enabled", 64'(irq), 64'h1);
        wr(AD_STAT, 32'h1);
        rd(AD_STAT, v); chk("R8 set wins", 64'(v), 64'h1);
        wr(AD_C0LO, 32'd200);
        @(negedge clk);
        rd(AD_STAT, v); chk("R9 sticky", 64'(v), 64'h1);
        wr(AD_STAT, 32'h1);
        rd(AD_STAT, v); chk("R8 w1c", 64'(v), 64'h0);
        chk("R10 irq drops", 64'(irq), 64'h0);

        // R11 test register
        wr(AD_TEST, 32'h2);
        rd(AD_STAT, v); chk("R11 test sets", 64'(v), 64'h2);
        rd(AD_TEST, v); chk("R11 reads zero", 64'(v), 64'h0);
        chk("R10 ch1 masked", 64'(irq), 64'h0);
        wr(AD_STAT, 32'h2);
        @(negedge clk);
        rd(AD_STAT, v); chk("R11 cleared", 64'(v), 64'h0);

        // R6 write beats increment
        wr(AD_CFG, 32'h0001_0000);
        wr(AD_CLO, 32'd5);
        wr(AD_CTRL, 32'h1);
        wr(AD_CLO, 32'd50);
        rd(AD_CLO, v); chk("R6 write wins", 64'(v), 64'd50);
        wr(AD_CTRL, 32'h0);
        rd(AD_CLO, v); chk("R6 next tick", 64'(v), 64'd51);

        // R7 greater-than via tick with carry (R5)
        wr(AD_CLO, 32'hFFFF_FFFE); wr(AD_CHI, 32'h0);
        wr(AD_C1LO, 32'h0); wr(AD_C1HI, 32'h1);
        wr(AD_CFG, 32'h0003_0000);
        wr(AD_STAT, 32'h2);
        wr(AD_CTRL, 32'h1);
        wr(AD_CTRL, 32'h0);
        rd(AD_CHI, v); chk("R5 carry", 64'(v), 64'h1);
        rd(AD_STAT, v); chk("R7 latency", 64'(v & 32'h2), 64'h0);
        @(negedge clk);
        rd(AD_STAT, v); chk("R7 greater expires", 64'(v & 32'h2), 64'h2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule